// File: doc/BRIEF.md
# ADC Track-and-Convert Sequencer

This block is the digital control sequencer that sits beside a successive-approximation converter. It chooses one conversion-start source from a 3-bit mode field: a software strobe, one of four timer-overflow strobes, or an external convert-start pin. It then steps through an optional tracking phase and a fixed-length conversion phase. Every phase is counted in SAR clock-enable cycles. A track/hold control output tells the analog front end when to follow the input. A busy flag covers the whole sequence. A single-cycle done pulse marks the end of each conversion.

Two tracking policies are supported. With the low-power bit clear, the input is followed at all times except during a conversion. With the bit set, an internally triggered conversion gets a fixed 3-clock tracking window before it. An externally triggered conversion instead tracks while the pin is low and converts from the pin's rising edge. A standby request shuts tracking off regardless of phase.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0, and `track_en` is 1 when `lp_track`=0 and `standby`=0.
- R2: Internal start codes on `start_mode` are: 000 software strobe `sw_start`, 001 `tmr_ovf[0]`, 010 `tmr_ovf[2]`, 011 `tmr_ovf[1]`, 101 `tmr_ovf[3]`. Only the selected strobe starts a conversion. `busy` is 1 from the clock edge that samples the accepted strobe.
- R3: Code 100 selects `ext_cnv`. The pin passes through two synchronizing flops before rising-edge detection, so `busy` goes to 1 on the third clock edge after the pin rises. With `lp_track`=0 the conversion starts at once, with no extra tracking.
- R4: Codes 110 and 111 select no source: no strobe, timer or pin edge starts a conversion.
- R5: With `lp_track`=0, `track_en` is 1 whenever the block is idle and not in standby, and 0 for the whole conversion phase.
- R6: The conversion phase lasts exactly 11 SAR clock-enable cycles. `done` is then high for one clock cycle, and `busy` falls on that same edge.
- R7: With `lp_track`=1 and an internal source, a 3-enable-cycle tracking window (`track_en`=1) precedes the conversion, so done arrives 14 enable cycles after acceptance. `track_en` is 0 while idle in this mode.
- R8: With `lp_track`=1 and code 100, `track_en` follows the synchronized pin while idle: 1 when it is low, 0 when it is high. The rising edge starts the conversion directly, and done comes after 11 enable cycles.
- R9: A start event that arrives while `busy` is 1 is ignored and is not queued: no second conversion follows.
- R10: While `standby` is 1, `track_en` is 0.
- R11: Phase counters advance only on cycles where `sar_ce` is 1. With a divided enable, the done timing counts enable cycles, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sar_ce | input | 1 | SAR clock enable, one clk cycle per SAR clock |
| lp_track | input | 1 | 1 selects the low-power tracking policy |
| start_mode | input | 3 | Start-source select code |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer overflow strobes, bit n = timer n |
| ext_cnv | input | 1 | Asynchronous external convert-start pin |
| standby | input | 1 | Standby/sleep request, disables tracking |
| track_en | output | 1 | Track/hold control, 1 = track |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest situation to reach is a start event landing in the middle of a sequence while the SAR enable is divided. In that case both the non-queuing rule and the enable-only counting must hold together. The bench generates `sar_ce` itself on a programmable divide pattern. It keeps its own count of the enable cycles the design has seen since acceptance, and fires a second strobe several enables into the conversion. It then requires done on exactly the 11th enable and no further busy period afterwards. The low-power external case is reached by parking the pin low to observe tracking, then raising it and counting synchronizer edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DEF_TRACK_CLKS  = 3;
    localparam int DEF_CONV_CLKS   = 11;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int NUM_TMR         = 4;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LPTRACK = 2'd1,
        PH_CONV    = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        SRC_SW   = 3'b000,
        SRC_TMR0 = 3'b001,
        SRC_TMR2 = 3'b010,
        SRC_TMR1 = 3'b011,
        SRC_EXT  = 3'b100,
        SRC_TMR3 = 3'b101,
        SRC_NONE6 = 3'b110,
        SRC_NONE7 = 3'b111
    } src_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Select the start strobe that the current source code points at.
    function automatic logic pick_start(input src_e mode, input logic sw,
                                        input logic [NUM_TMR-1:0] tmr,
                                        input logic pin_rise);
        logic s;
        case (mode)
            SRC_SW:   s = sw;
            SRC_TMR0: s = tmr[0];
            SRC_TMR1: s = tmr[1];
            SRC_TMR2: s = tmr[2];
            SRC_TMR3: s = tmr[3];
            SRC_EXT:  s = pin_rise;
            default:  s = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_lvl,
    output logic pin_rise
);
    logic [STAGES-1:0] chain;
    logic              lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            lvl_q <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_async};
            lvl_q <= chain[STAGES-1];
        end
    end

    assign pin_lvl  = chain[STAGES-1];
    assign pin_rise = chain[STAGES-1] & ~lvl_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic [2:0]         start_mode,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               pin_rise,
    output logic               start_evt,
    output logic               src_is_ext
);
    src_e mode;

    always_comb begin
        mode       = src_e'(start_mode);
        start_evt  = pick_start(mode, sw_start, tmr_ovf, pin_rise);
        src_is_ext = (mode == SRC_EXT);
    end
endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CLKS = DEF_TRACK_CLKS,
    parameter int CONV_CLKS  = DEF_CONV_CLKS,
    parameter int CNT_W      = $clog2(max_of(TRACK_CLKS, CONV_CLKS) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sar_ce,
    input  logic             lp_track,
    input  logic             start_evt,
    input  logic             src_is_ext,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_CLKS - 1);
    localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_evt) begin
                        busy  <= 1'b1;
                        cnt   <= '0;
                        phase <= (lp_track && !src_is_ext) ? PH_LPTRACK : PH_CONV;
                    end
                end
                PH_LPTRACK: begin
                    if (sar_ce) begin
                        if (cnt == TRACK_LAST) begin
                            cnt   <= '0;
                            phase <= PH_CONV;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CONV: begin
                    if (sar_ce) begin
                        if (cnt == CONV_LAST) begin
                            cnt   <= '0;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            phase <= PH_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                    busy  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CLKS  = DEF_TRACK_CLKS,
    parameter int CONV_CLKS   = DEF_CONV_CLKS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sar_ce,
    input  logic               lp_track,
    input  logic [2:0]         start_mode,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ext_cnv,
    input  logic               standby,
    output logic               track_en,
    output logic               busy,
    output logic               done
);
    localparam int CNT_W = $clog2(max_of(TRACK_CLKS, CONV_CLKS) + 1);

    logic             pin_lvl;
    logic             pin_rise;
    logic             start_evt;
    logic             src_is_ext;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             idle_track;

    adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_cnv),
        .pin_lvl   (pin_lvl),
        .pin_rise  (pin_rise)
    );

    adc_trig_sel u_sel (
        .start_mode (start_mode),
        .sw_start   (sw_start),
        .tmr_ovf    (tmr_ovf),
        .pin_rise   (pin_rise),
        .start_evt  (start_evt),
        .src_is_ext (src_is_ext)
    );

    adc_phase_fsm #(
        .TRACK_CLKS (TRACK_CLKS),
        .CONV_CLKS  (CONV_CLKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sar_ce     (sar_ce),
        .lp_track   (lp_track),
        .start_evt  (start_evt),
        .src_is_ext (src_is_ext),
        .phase      (phase),
        .cnt        (cnt),
        .busy       (busy),
        .done       (done)
    );

    // Idle tracking: always in continuous mode; in low-power mode only
    // while an external-trigger pin is held low.
    always_comb begin
        idle_track = !lp_track || (src_is_ext && !pin_lvl);
        track_en   = !standby &&
                     (((phase == PH_IDLE) && idle_track) || (phase == PH_LPTRACK));
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int TRACK_CLKS = DEF_TRACK_CLKS,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sar_ce,
    input logic             standby,
    input logic [2:0]       start_mode,
    input logic             track_en,
    input logic             busy,
    input logic             done,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt
);
    p_done_clears_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_standby_r10: assert property (@(posedge clk) disable iff (rst)
        standby |-> !track_en);

    p_conv_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV) |-> !track_en);

    p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !sar_ce) |=> ($stable(cnt) && $stable(phase)));

    p_track_window_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LPTRACK) |-> (cnt < CNT_W'(TRACK_CLKS)));

    p_no_source_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_mode[2:1] == 2'b11) |=> !busy);
endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .TRACK_CLKS (TRACK_CLKS),
    .CNT_W      (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sar_ce     (sar_ce),
    .standby    (standby),
    .start_mode (start_mode),
    .track_en   (track_en),
    .busy       (busy),
    .done       (done),
    .phase      (phase),
    .cnt        (cnt)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sar_ce = 1'b1;
    logic       lp_track = 1'b0;
    logic [2:0] start_mode = 3'b000;
    logic       sw_start = 1'b0;
    logic [3:0] tmr_ovf = 4'b0;
    logic       ext_cnv = 1'b0;
    logic       standby = 1'b0;
    logic       track_en, busy, done;

    int checks = 0;
    int errors = 0;
    int ce_div = 1;
    int ce_phase = 0;
    int ce_cnt = 0;
    int trk_cnt = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .sar_ce(sar_ce), .lp_track(lp_track),
        .start_mode(start_mode), .sw_start(sw_start), .tmr_ovf(tmr_ovf),
        .ext_cnv(ext_cnv), .standby(standby),
        .track_en(track_en), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: count enables the design saw, then set next enable.
    task automatic tick();
        @(posedge clk);
        if (sar_ce) ce_cnt++;
        cycles++;
        @(negedge clk);
        if (track_en) trk_cnt++;
        ce_phase = (ce_phase + 1) % ce_div;
        sar_ce = (ce_phase == 0);
    endtask

    task automatic run_until_done(output int got_ce);
        int guard = 0;
        while (!done && guard < 400) begin
            tick();
            guard++;
        end
        got_ce = done ? ce_cnt : -1;
    endtask

    task automatic pulse_src(input int which);
        // which: 0..3 timer index, 4 software
        if (which == 4) sw_start = 1'b1; else tmr_ovf[which] = 1'b1;
        tick();
        sw_start = 1'b0;
        tmr_ovf = 4'b0;
    endtask

    task automatic t_reset();
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 track_en after reset", track_en, 1);
    endtask

    task automatic t_cont_conv();
        int n;
        lp_track = 1'b0; start_mode = 3'b000;
        pulse_src(4);
        check("R2 busy on sw start", busy, 1);
        check("R5 no tracking in conversion", track_en, 0);
        ce_cnt = 0;
        run_until_done(n);
        check("R6 conversion enables", n, 11);
        check("R6 busy cleared with done", busy, 0);
        tick();
        check("R6 done one cycle", done, 0);
        check("R5 tracking resumes idle", track_en, 1);
    endtask

    task automatic t_modes();
        int n;
        int codes[5] = '{0, 1, 2, 3, 5};
        int srcs[5]  = '{4, 0, 2, 1, 3};
        for (int i = 0; i < 5; i++) begin
            start_mode = 3'(codes[i]);
            pulse_src((srcs[i] + 1) % 5);
            check("R2 unselected source ignored", busy, 0);
            pulse_src(srcs[i]);
            check("R2 selected source starts", busy, 1);
            ce_cnt = 0;
            run_until_done(n);
            check("R2 conversion completes", n, 11);
            tick();
        end
    endtask

    task automatic t_no_source();
        for (int c = 6; c < 8; c++) begin
            start_mode = 3'(c);
            for (int s = 0; s < 5; s++) pulse_src(s);
            ext_cnv = 1'b1; tick(); tick(); tick(); tick();
            check("R4 no source starts", busy, 0);
            ext_cnv = 1'b0; tick(); tick(); tick();
        end
    endtask

    task automatic t_ext_cont();
        int n;
        lp_track = 1'b0; start_mode = 3'b100;
        ext_cnv = 1'b1;
        tick(); tick();
        check("R3 not started before sync", busy, 0);
        tick();
        check("R3 started on third edge", busy, 1);
        ce_cnt = 0;
        run_until_done(n);
        check("R3 ext conversion enables", n, 11);
        ext_cnv = 1'b0; tick(); tick(); tick();
    endtask

    task automatic t_lp_internal();
        int n;
        lp_track = 1'b1; start_mode = 3'b000;
        tick();
        check("R7 idle no tracking low-power", track_en, 0);
        pulse_src(4);
        check("R7 tracking after start", track_en, 1);
        ce_cnt = 0; trk_cnt = 0;
        run_until_done(n);
        check("R7 total enables", n, 14);
        check("R7 tracking samples after start", trk_cnt, 2);
        tick();
    endtask

    task automatic t_lp_ext();
        int n;
        lp_track = 1'b1; start_mode = 3'b100; ext_cnv = 1'b0;
        tick(); tick(); tick();
        check("R8 tracks while pin low", track_en, 1);
        ext_cnv = 1'b1;
        tick(); tick();
        check("R8 pin high stops tracking", track_en, 0);
        check("R8 not yet started", busy, 0);
        tick();
        check("R8 started on edge", busy, 1);
        ce_cnt = 0;
        run_until_done(n);
        check("R8 no extra tracking", n, 11);
        ext_cnv = 1'b0; tick(); tick(); tick();
        lp_track = 1'b0;
    endtask

    task automatic t_busy_ignore_div();
        int n;
        int again = 0;
        ce_div = 3; ce_phase = 0; sar_ce = 1'b1;
        lp_track = 1'b0; start_mode = 3'b000;
        pulse_src(4);
        ce_cnt = 0;
        for (int k = 0; k < 7; k++) tick();
        check("R11 enables counted in divided run", ce_cnt, 2);
        pulse_src(4);
        run_until_done(n);
        check("R11 done after 11 enables", n, 11);
        check("R11 clock cycles exceed enables", (cycles > n) ? 1 : 0, 1);
        for (int k = 0; k < 60; k++) begin
            tick();
            if (busy) again = 1;
        end
        check("R9 start while busy not queued", again, 0);
        ce_div = 1; ce_phase = 0; sar_ce = 1'b1;
    endtask

    task automatic t_standby();
        lp_track = 1'b0; start_mode = 3'b000;
        standby = 1'b1;
        tick();
        check("R10 standby idle no tracking", track_en, 0);
        lp_track = 1'b1;
        pulse_src(4);
        check("R10 standby blocks lp window", track_en, 0);
        while (busy) tick();
        standby = 1'b0; lp_track = 1'b0;
        tick();
        check("R10 tracking back after standby", track_en, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_cont_conv();
        t_modes();
        t_no_source();
        t_ext_cont();
        t_lp_internal();
        t_lp_ext();
        t_busy_ignore_div();
        t_standby();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule